// File: doc/BRIEF.md
# PWM Output Mode and Pin Steering

This block sits between a PWM duty generator and the two pins of one output pair. It turns one or two raw duty signals into a high-side and a low-side drive. Three pairing modes are available: complementary with a programmable dead time, independent, and push-pull alternation. A software override can replace the pair. The override either passes through the dead-time logic or bypasses it. After that, the block can exchange the two sides, invert each pin separately, and release either pin through its own port enable.

Configuration is loaded from a plain write strobe. A write is dropped while the generator is running or while a separate lock input is high, so the pin mapping cannot change under a live power stage. Timebase and duty generation happen upstream. The duty and override inputs are level signals sampled every clock. There is no handshake and no back-pressure: the pins follow the inputs with a fixed latency.

Top module: `pwmo_top`

## Requirements
- R1: After reset, all configuration fields are zero, both pin drives are low and both output enables are low.
- R2: In complementary mode (mode code 00), the high side follows `pwm_a` and the low side is its inverse, two clock edges after the input changes.
- R3: In complementary mode with a non-zero dead time D, every change of the requested pair holds both logical outputs inactive for exactly D clock cycles. After that, the newly active side turns on. A side that turns off does so without delay.
- R4: In independent mode (mode code 01), the high side follows `pwm_a` and the low side follows `pwm_b`, with no dead time.
- R5: In push-pull mode (mode code 10), `pwm_a` is steered to the high side while an internal phase bit is 0 and to the low side while it is 1. The phase is 0 after reset and flips on every clock edge that sees `period_start` high. The inactive side stays low.
- R6: Mode code 11 drives both logical outputs inactive.
- R7: With `force_on` = 0, an override replaces the requested pair before the dead-time stage, so it is delayed and blanked like a duty edge.
- R8: With `force_on` = 1, an override reaches the pins one clock edge after it is applied, without dead-time blanking.
- R9: With swap = 1, the high-side logical signal drives the L pin and the low-side signal drives the H pin.
- R10: A polarity bit of 1 makes its pin active-low: the pin level is the logical level inverted. Polarity is applied after swap and belongs to the physical pin.
- R11: A port enable of 0 deasserts that pin's output enable and holds its drive low.
- R12: A configuration write while `gen_on` is high has no effect.
- R13: A configuration write while `cfg_lock` is high has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gen_on | input | 1 | Generator running; blocks configuration writes |
| cfg_lock | input | 1 | Lock; blocks configuration writes |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_mode | input | 2 | Pairing mode: 00 complementary, 01 independent, 10 push-pull, 11 reserved |
| cfg_swap | input | 1 | Exchange high and low sides at the pins |
| cfg_force_on | input | 1 | Override bypasses dead time |
| cfg_pol_h | input | 1 | H pin active-low when 1 |
| cfg_pol_l | input | 1 | L pin active-low when 1 |
| cfg_en_h | input | 1 | H pin port enable |
| cfg_en_l | input | 1 | L pin port enable |
| cfg_dead | input | DT_W | Dead time in clock cycles |
| period_start | input | 1 | One pulse per PWM period; flips the push-pull phase |
| pwm_a | input | 1 | Primary duty signal |
| pwm_b | input | 1 | Second duty signal for independent mode |
| ovr_req | input | 1 | Override active |
| ovr_h | input | 1 | Override logical level for the high side |
| ovr_l | input | 1 | Override logical level for the low side |
| pwm_h_o | output | 1 | H pin drive |
| pwm_l_o | output | 1 | L pin drive |
| pwm_h_oe | output | 1 | H pin output enable |
| pwm_l_oe | output | 1 | L pin output enable |

## Verification
The bench builds the block with a 4-bit dead-time field. Every dead-time value up to 15 is then legal, and the blanking windows of 2 and 3 cycles used in the directed tests finish in a few cycles. The bench walks each window edge by edge. This shows the exact cycle at which one side drops and the other rises. It also shows the one-cycle gap between an override that bypasses the dead time and one that goes through it.

// File: rtl/pwmo_pkg.sv
package pwmo_pkg;

  typedef enum logic [1:0] {
    MODE_COMP     = 2'b00,
    MODE_INDEP    = 2'b01,
    MODE_PUSHPULL = 2'b10,
    MODE_RSVD     = 2'b11
  } pwmo_mode_e;

  // Index 1 is the high side / H pin, index 0 the low side / L pin.
  localparam int SIDE_H = 1;
  localparam int SIDE_L = 0;
  localparam int NUM_SIDES = 2;

  typedef struct packed {
    pwmo_mode_e             mode;
    logic                   swap;
    logic                   force_on;
    logic [NUM_SIDES-1:0]   pol;
    logic [NUM_SIDES-1:0]   en;
  } pwmo_cfg_t;

endpackage

// File: rtl/pwmo_cfg_reg.sv
module pwmo_cfg_reg
  import pwmo_pkg::*;
#(
  parameter int DT_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            gen_on,
  input  logic            lock,
  input  logic            we,
  input  pwmo_cfg_t       wr_cfg,
  input  logic [DT_W-1:0] wr_dead,
  output pwmo_cfg_t       cfg,
  output logic [DT_W-1:0] dead
);

  logic accept;
  assign accept = we && !gen_on && !lock;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg  <= '0;
      dead <= '0;
    end else if (accept) begin
      cfg  <= wr_cfg;
      dead <= wr_dead;
    end
  end

endmodule

// File: rtl/pwmo_mode_mux.sv
module pwmo_mode_mux
  import pwmo_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  pwmo_mode_e mode,
  input  logic       force_on,
  input  logic       period_start,
  input  logic       pwm_a,
  input  logic       pwm_b,
  input  logic       ovr_req,
  input  logic [1:0] ovr_pair,
  output logic [1:0] req_pair
);

  logic phase;

  always_ff @(posedge clk) begin
    if (!rst_n)            phase <= 1'b0;
    else if (period_start) phase <= ~phase;
  end

  always_comb begin
    case (mode)
      MODE_COMP:     req_pair = {pwm_a, ~pwm_a};
      MODE_INDEP:    req_pair = {pwm_a, pwm_b};
      MODE_PUSHPULL: req_pair = {pwm_a & ~phase, pwm_a & phase};
      default:       req_pair = 2'b00;
    endcase
    // A dead-time-respecting override enters ahead of the blanking stage.
    if (ovr_req && !force_on) req_pair = ovr_pair;
  end

endmodule

// File: rtl/pwmo_deadtime.sv
module pwmo_deadtime #(
  parameter int DT_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            comp_mode,
  input  logic [DT_W-1:0] dead,
  input  logic [1:0]      req_pair,
  output logic [1:0]      dt_pair
);

  logic [1:0]      last;
  logic [DT_W-1:0] cnt;
  logic            chg;

  assign chg = (req_pair != last);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last <= 2'b00;
      cnt  <= '0;
    end else begin
      last <= req_pair;
      if (comp_mode && chg) cnt <= dead;
      else if (cnt != '0)   cnt <= cnt - 1'b1;
    end
  end

  // Turn-off passes at once through "last"; turn-on waits for the count.
  assign dt_pair = (comp_mode && cnt != '0) ? 2'b00 : last;

endmodule

// File: rtl/pwmo_pin_drv.sv
module pwmo_pin_drv (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  input  logic pol,
  input  logic en,
  output logic pin,
  output logic oe
);

  always_ff @(posedge clk) begin
    if (!rst_n) pin <= 1'b0;
    else        pin <= en ? (lvl ^ pol) : 1'b0;
  end

  assign oe = en;

endmodule

// File: rtl/pwmo_top.sv
module pwmo_top
  import pwmo_pkg::*;
#(
  parameter int DT_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            gen_on,
  input  logic            cfg_lock,
  input  logic            cfg_we,
  input  logic [1:0]      cfg_mode,
  input  logic            cfg_swap,
  input  logic            cfg_force_on,
  input  logic            cfg_pol_h,
  input  logic            cfg_pol_l,
  input  logic            cfg_en_h,
  input  logic            cfg_en_l,
  input  logic [DT_W-1:0] cfg_dead,
  input  logic            period_start,
  input  logic            pwm_a,
  input  logic            pwm_b,
  input  logic            ovr_req,
  input  logic            ovr_h,
  input  logic            ovr_l,
  output logic            pwm_h_o,
  output logic            pwm_l_o,
  output logic            pwm_h_oe,
  output logic            pwm_l_oe
);

  pwmo_cfg_t            wr_cfg;
  pwmo_cfg_t            cfg_q;
  logic [DT_W-1:0]      dead_q;
  logic [1:0]           ovr_pair;
  logic [1:0]           req_pair;
  logic [1:0]           dt_pair;
  logic [1:0]           fin_pair;
  logic [NUM_SIDES-1:0] pin_lvl;
  logic [NUM_SIDES-1:0] pin_v;
  logic [NUM_SIDES-1:0] oe_v;

  always_comb begin
    wr_cfg.mode     = pwmo_mode_e'(cfg_mode);
    wr_cfg.swap     = cfg_swap;
    wr_cfg.force_on = cfg_force_on;
    wr_cfg.pol      = {cfg_pol_h, cfg_pol_l};
    wr_cfg.en       = {cfg_en_h, cfg_en_l};
  end

  assign ovr_pair = {ovr_h, ovr_l};

  pwmo_cfg_reg #(.DT_W(DT_W)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .gen_on  (gen_on),
    .lock    (cfg_lock),
    .we      (cfg_we),
    .wr_cfg  (wr_cfg),
    .wr_dead (cfg_dead),
    .cfg     (cfg_q),
    .dead    (dead_q)
  );

  pwmo_mode_mux u_mode (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode         (cfg_q.mode),
    .force_on     (cfg_q.force_on),
    .period_start (period_start),
    .pwm_a        (pwm_a),
    .pwm_b        (pwm_b),
    .ovr_req      (ovr_req),
    .ovr_pair     (ovr_pair),
    .req_pair     (req_pair)
  );

  pwmo_deadtime #(.DT_W(DT_W)) u_dt (
    .clk       (clk),
    .rst_n     (rst_n),
    .comp_mode (cfg_q.mode == MODE_COMP),
    .dead      (dead_q),
    .req_pair  (req_pair),
    .dt_pair   (dt_pair)
  );

  // Immediate override lands after the blanking stage.
  assign fin_pair = (ovr_req && cfg_q.force_on) ? ovr_pair : dt_pair;
  assign pin_lvl  = cfg_q.swap ? {fin_pair[SIDE_L], fin_pair[SIDE_H]} : fin_pair;

  for (genvar gi = 0; gi < NUM_SIDES; gi++) begin : g_pin
    pwmo_pin_drv u_drv (
      .clk   (clk),
      .rst_n (rst_n),
      .lvl   (pin_lvl[gi]),
      .pol   (cfg_q.pol[gi]),
      .en    (cfg_q.en[gi]),
      .pin   (pin_v[gi]),
      .oe    (oe_v[gi])
    );
  end

  assign pwm_h_o  = pin_v[SIDE_H];
  assign pwm_l_o  = pin_v[SIDE_L];
  assign pwm_h_oe = oe_v[SIDE_H];
  assign pwm_l_oe = oe_v[SIDE_L];

endmodule

// File: rtl/pwmo_chk.sv
module pwmo_chk
  import pwmo_pkg::*;
#(
  parameter int DT_W = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            gen_on,
  input logic            cfg_lock,
  input logic            cfg_we,
  input logic            ovr_req,
  input logic            ovr_h,
  input pwmo_cfg_t       cfg,
  input logic [DT_W-1:0] dead,
  input logic [1:0]      req_pair,
  input logic [1:0]      dt_pair,
  input logic            pwm_h_o
);

  assert_wr_block_run_R12: assert property (@(posedge clk) disable iff (!rst_n)
    gen_on |=> ($stable(cfg) && $stable(dead)));

  assert_wr_block_lock_R13: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_lock |=> ($stable(cfg) && $stable(dead)));

  assert_dt_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.mode == MODE_COMP && dead != '0 && !cfg_we && req_pair != $past(req_pair))
      |=> (dt_pair == 2'b00));

  assert_rsvd_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.mode == MODE_RSVD && !ovr_req && !cfg_we) |=> (dt_pair == 2'b00));

  assert_force_now_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_req && cfg.force_on && !cfg.swap && cfg.en[SIDE_H] && !cfg_we)
      |=> (pwm_h_o == ($past(ovr_h) ^ cfg.pol[SIDE_H])));

endmodule

bind pwmo_top pwmo_chk #(.DT_W(DT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .gen_on   (gen_on),
  .cfg_lock (cfg_lock),
  .cfg_we   (cfg_we),
  .ovr_req  (ovr_req),
  .ovr_h    (ovr_h),
  .cfg      (cfg_q),
  .dead     (dead_q),
  .req_pair (req_pair),
  .dt_pair  (dt_pair),
  .pwm_h_o  (pwm_h_o)
);

// File: tb/pwmo_top_tb_top.sv
`timescale 1ns/1ps
module pwmo_top_tb_top;

  localparam int DT_W = 4;
  localparam int NVEC = 12;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic            rst_n, gen_on, cfg_lock, cfg_we;
  logic [1:0]      cfg_mode;
  logic            cfg_swap, cfg_force_on, cfg_pol_h, cfg_pol_l, cfg_en_h, cfg_en_l;
  logic [DT_W-1:0] cfg_dead;
  logic            period_start, pwm_a, pwm_b, ovr_req, ovr_h, ovr_l;
  logic            pwm_h_o, pwm_l_o, pwm_h_oe, pwm_l_oe;

  pwmo_top #(.DT_W(DT_W)) dut_i (.*);

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 1'b0;

  // {mode[1:0], swap, pol_h, pol_l, en_h, en_l, a, b, exp_h, exp_l, exp_oe_h, exp_oe_l}
  localparam logic [12:0] VEC [NVEC] = '{
    13'b00_0_00_11_10_10_11,  // complementary, a=1
    13'b00_0_00_11_00_01_11,  // complementary, a=0
    13'b01_0_00_11_11_11_11,  // independent 1/1
    13'b01_0_00_11_01_01_11,  // independent 0/1
    13'b11_0_00_11_11_00_11,  // reserved code, active-high
    13'b11_0_11_11_11_11_11,  // reserved code, active-low
    13'b00_1_00_11_10_01_11,  // complementary swapped
    13'b01_1_10_11_10_11_11,  // independent swapped, H inverted
    13'b00_0_10_11_10_00_11,  // complementary, H inverted
    13'b01_0_00_01_11_01_01,  // H disabled
    13'b01_0_11_00_00_00_00,  // both disabled
    13'b00_0_01_10_00_00_10   // L disabled, L inverted
  };

  task automatic step(int n = 1);
    repeat (n) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic chk(string req, logic [3:0] expv);
    logic [3:0] act;
    act = {pwm_h_o, pwm_l_o, pwm_h_oe, pwm_l_oe};
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s: {h,l,oe_h,oe_l} got %b expected %b", req, act, expv);
    end
  endtask

  task automatic wr(logic [1:0] m, logic sw, logic fon, logic ph, logic pl,
                    logic eh, logic el, logic [DT_W-1:0] d);
    cfg_mode = m; cfg_swap = sw; cfg_force_on = fon;
    cfg_pol_h = ph; cfg_pol_l = pl; cfg_en_h = eh; cfg_en_l = el; cfg_dead = d;
    cfg_we = 1'b1;
    step(1);
    cfg_we = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog R1: got hung run expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; gen_on = 1'b0; cfg_lock = 1'b0; cfg_we = 1'b0;
    cfg_mode = 2'b00; cfg_swap = 1'b0; cfg_force_on = 1'b0;
    cfg_pol_h = 1'b0; cfg_pol_l = 1'b0; cfg_en_h = 1'b0; cfg_en_l = 1'b0;
    cfg_dead = '0; period_start = 1'b0; pwm_a = 1'b0; pwm_b = 1'b0;
    ovr_req = 1'b0; ovr_h = 1'b0; ovr_l = 1'b0;
    step(3);
    rst_n = 1'b1;
    step(1);
    chk("R1 reset state", 4'b0000);

    // Vector table: R2 R4 R6 R9 R10 R11
    for (int i = 0; i < NVEC; i++) begin
      pwm_a = VEC[i][5];
      pwm_b = VEC[i][4];
      wr(VEC[i][12:11], VEC[i][10], 1'b0, VEC[i][9], VEC[i][8],
         VEC[i][7], VEC[i][6], '0);
      step(3);
      chk($sformatf("table vector %0d (R2 R4 R6 R9 R10 R11)", i), VEC[i][3:0]);
    end

    // R2: two-edge latency
    pwm_a = 1'b0;
    wr(2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 4'd0);
    step(3);
    chk("R2 steady low", 4'b0111);
    pwm_a = 1'b1;
    step(1); chk("R2 one edge later", 4'b0111);
    step(1); chk("R2 two edges later", 4'b1011);

    // R3: dead time of 3 on both edges
    pwm_a = 1'b0;
    wr(2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 4'd3);
    step(4);
    chk("R3 start", 4'b0111);
    pwm_a = 1'b1;
    step(1); chk("R3 rise edge1", 4'b0111);
    step(1); chk("R3 rise gap1", 4'b0011);
    step(1); chk("R3 rise gap2", 4'b0011);
    step(1); chk("R3 rise gap3", 4'b0011);
    step(1); chk("R3 rise H on", 4'b1011);
    pwm_a = 1'b0;
    step(2); chk("R3 fall H off at once", 4'b0011);
    step(3); chk("R3 fall L on", 4'b0111);

    // R5: push-pull phase alternation
    pwm_a = 1'b1;
    wr(2'b10, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 4'd0);
    step(3);
    chk("R5 phase 0 to H", 4'b1011);
    period_start = 1'b1; step(1); period_start = 1'b0; step(2);
    chk("R5 phase 1 to L", 4'b0111);
    period_start = 1'b1; step(1); period_start = 1'b0; step(2);
    chk("R5 back to H", 4'b1011);
    pwm_a = 1'b0;
    step(2);
    chk("R5 both idle", 4'b0011);

    // R7: override through dead time
    pwm_a = 1'b0;
    wr(2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 4'd2);
    step(4);
    chk("R7 start", 4'b0111);
    ovr_h = 1'b1; ovr_l = 1'b0; ovr_req = 1'b1;
    step(1); chk("R7 edge1", 4'b0111);
    step(1); chk("R7 gap1", 4'b0011);
    step(1); chk("R7 gap2", 4'b0011);
    step(1); chk("R7 override on", 4'b1011);
    ovr_req = 1'b0;
    step(6);

    // R8: immediate override
    wr(2'b00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 4'd2);
    step(4);
    chk("R8 start", 4'b0111);
    ovr_req = 1'b1;
    step(1); chk("R8 override after one edge", 4'b1011);
    ovr_req = 1'b0;
    step(1); chk("R8 release after one edge", 4'b0111);

    // R12: write while running is dropped
    pwm_a = 1'b1; pwm_b = 1'b0;
    wr(2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 4'd0);
    step(3);
    chk("R12 baseline", 4'b1011);
    gen_on = 1'b1;
    wr(2'b01, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 4'd0);
    step(3);
    gen_on = 1'b0;
    step(1);
    chk("R12 write ignored while running", 4'b1011);
    wr(2'b01, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 4'd0);
    step(3);
    chk("R12 write taken when stopped", 4'b1111);

    // R13: write while locked is dropped
    cfg_lock = 1'b1;
    wr(2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 4'd0);
    step(3);
    chk("R13 write ignored while locked", 4'b1111);
    cfg_lock = 1'b0;

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule